// File: doc/BRIEF.md
# Wheel Traversability Height Checker

This block decides whether one cell of a terrain height map can be crossed by a wheel. The centre cell height is compared against the heights of all cells in a forward half-disc around it. That half-disc is bounded by the wheel radius and lies ahead of the cell in the direction of travel. All neighbour heights arrive together as one wide vector, one lane per memory bank, so every difference is evaluated in the same step. A per-lane enable mask selects which lanes belong to the half-disc. The default is 110 lanes, which fit an 8 x 15 bounding rectangle.

A cell counts as road only when every enabled neighbour differs from the centre by no more than the threshold, in either direction, with both bounds included. Heights and the threshold are signed 12-bit values. Differences are formed at 13 bits, so no pair of inputs can overflow. A new cell can be presented on every clock. Its verdict appears exactly two cycles later, together with a one-cycle valid strobe.

The output stage is a two-state machine. `OUT_IDLE` means no result is being presented. `OUT_EMIT` means the flag holds a fresh verdict. IDLE moves to EMIT when a compared lane set leaves the first stage. EMIT stays in EMIT while further sets follow back to back. EMIT returns to IDLE when none follows. IDLE stays in IDLE otherwise.

Top module: `trav_checker`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and in the cycle after it is released, `out_valid` and `is_road` are 0.
- R2: A neighbour whose height difference (neighbour minus centre) equals exactly +`hmax` or exactly -`hmax` does not prevent a road verdict.
- R3: A single enabled neighbour whose difference is `hmax`+1 or -(`hmax`+1) makes the verdict not-road (`is_road`=0).
- R4: The verdict is road (`is_road`=1) only if every enabled lane passes; one failing lane anywhere (first, middle or last index) forces not-road.
- R5: A lane whose bit in `lane_en` is 0 has no effect on the verdict, whatever its height.
- R6: When `lane_en` is all zeros, the verdict is road.
- R7: Differences are computed without overflow across the full signed 12-bit range; for example, centre -2048 with neighbour 2047 under `hmax`=2047 gives not-road.
- R8: `out_valid` is high exactly in the cycle two clocks after a cycle with `in_valid` high. Inputs may be presented on consecutive cycles, and each verdict belongs to its own input.
- R9: A negative `hmax` makes the verdict not-road whenever at least one lane is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs present a cell to evaluate this cycle |
| center_h | input | HW (12) | Signed height of the centre cell |
| nbr_h | input | LANES*HW (1320) | Signed neighbour heights; lane i occupies bits [i*HW +: HW] |
| lane_en | input | LANES (110) | Lane i takes part in the test when bit i is 1 |
| hmax | input | HW (12) | Signed height tolerance |
| out_valid | output | 1 | Verdict strobe, two cycles after `in_valid` |
| is_road | output | 1 | 1 = traversable, 0 = not; meaningful while `out_valid` is high |

## Verification
The hardest case to reach is a single offending lane hidden among 109 passing ones, sitting exactly one unit outside the tolerance at an edge lane index. Random heights almost never produce it. The directed tasks build the neighbour vector from the centre height plus chosen offsets, so that one lane lands at ±`hmax` or ±(`hmax`+1) at index 0, a middle index, or the last index. The same vectors are then repeated with that lane masked off. Back-to-back inputs with alternating verdicts show that results in the pipeline are not mixed up.

// File: rtl/trav_pkg.sv
package trav_pkg;
    localparam int TRAV_LANES_DEF = 110;
    localparam int TRAV_HW_DEF    = 12;

    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_EMIT = 1'b1
    } out_st_e;
endpackage

// File: rtl/trav_lane.sv
module trav_lane #(
    parameter int HW = 12
) (
    input  logic [HW-1:0] center,
    input  logic [HW-1:0] nbr,
    input  logic [HW-1:0] tol,
    input  logic          en,
    output logic          pass
);
    localparam int DW = HW + 1;

    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] tol_x;
    logic signed [DW-1:0] tol_neg;

    always_comb begin
        diff    = $signed({nbr[HW-1], nbr}) - $signed({center[HW-1], center});
        tol_x   = $signed({tol[HW-1], tol});
        tol_neg = -tol_x;
        pass    = !en || ((diff <= tol_x) && (diff >= tol_neg));
    end
endmodule

// File: rtl/trav_stage1.sv
module trav_stage1 #(
    parameter int LANES = 110,
    parameter int HW    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [HW-1:0]       center_h,
    input  logic [LANES*HW-1:0] nbr_h,
    input  logic [LANES-1:0]    lane_en,
    input  logic [HW-1:0]       hmax,
    output logic                s1_valid,
    output logic [LANES-1:0]    s1_pass
);
    logic [LANES-1:0] pass_c;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        trav_lane #(.HW(HW)) u_lane (
            .center (center_h),
            .nbr    (nbr_h[g*HW +: HW]),
            .tol    (hmax),
            .en     (lane_en[g]),
            .pass   (pass_c[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_pass  <= '1;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_pass <= pass_c;
            end
        end
    end
endmodule

// File: rtl/trav_checker.sv
module trav_checker
    import trav_pkg::*;
#(
    parameter int LANES = TRAV_LANES_DEF,
    parameter int HW    = TRAV_HW_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [HW-1:0]       center_h,
    input  logic [LANES*HW-1:0] nbr_h,
    input  logic [LANES-1:0]    lane_en,
    input  logic [HW-1:0]       hmax,
    output logic                out_valid,
    output logic                is_road
);
    logic             s1_valid;
    logic [LANES-1:0] s1_pass;
    out_st_e          st_q;
    out_st_e          st_d;
    logic             road_q;

    trav_stage1 #(.LANES(LANES), .HW(HW)) u_stage1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .center_h (center_h),
        .nbr_h    (nbr_h),
        .lane_en  (lane_en),
        .hmax     (hmax),
        .s1_valid (s1_valid),
        .s1_pass  (s1_pass)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OUT_IDLE: if (s1_valid)  st_d = OUT_EMIT;
            OUT_EMIT: if (!s1_valid) st_d = OUT_IDLE;
            default:  st_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= OUT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            road_q <= 1'b0;
        end else if (s1_valid) begin
            road_q <= &s1_pass;
        end
    end

    assign out_valid = (st_q == OUT_EMIT);
    assign is_road   = road_q;
endmodule

// File: rtl/trav_checker_sva.sv
module trav_checker_sva #(
    parameter int LANES = 110,
    parameter int HW    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [LANES-1:0] lane_en,
    input logic [HW-1:0]    hmax,
    input logic             out_valid,
    input logic             is_road
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !is_road));

    // R8
    latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R6
    empty_mask_road_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(in_valid, 2) && ($past(lane_en, 2) == '0)) |-> is_road);

    // R9
    neg_tol_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(in_valid, 2) && $past(hmax[HW-1], 2) && ($past(lane_en, 2) != '0))
        |-> !is_road);
endmodule

bind trav_checker trav_checker_sva #(.LANES(LANES), .HW(HW)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .lane_en   (lane_en),
    .hmax      (hmax),
    .out_valid (out_valid),
    .is_road   (is_road)
);

// File: tb/trav_checker_tb.sv
module trav_checker_tb;
    localparam int LANES = 110;
    localparam int HW    = 12;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [HW-1:0]       center_h = '0;
    logic [LANES*HW-1:0] nbr_h = '0;
    logic [LANES-1:0]    lane_en = '1;
    logic [HW-1:0]       hmax = '0;
    logic                out_valid;
    logic                is_road;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    trav_checker #(.LANES(LANES), .HW(HW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .center_h(center_h),
        .nbr_h(nbr_h), .lane_en(lane_en), .hmax(hmax),
        .out_valid(out_valid), .is_road(is_road)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    // every lane at centre + off
    task automatic fill(input int c, input int off);
        center_h = c[HW-1:0];
        for (int i = 0; i < LANES; i++) nbr_h[i*HW +: HW] = HW'(c + off);
    endtask

    task automatic set_lane(input int idx, input int v);
        nbr_h[idx*HW +: HW] = v[HW-1:0];
    endtask

    // one cell, sampled two cycles later
    task automatic run_one(input string tag, input logic exp_road);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid not early"}, out_valid, 1'b0);
        @(negedge clk);
        check({tag, " valid"}, out_valid, 1'b1);
        check({tag, " verdict"}, is_road, exp_road);
        @(negedge clk);
        check({tag, " valid drops"}, out_valid, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 reset valid", out_valid, 1'b0);
        check("R1 reset road", is_road, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-release valid", out_valid, 1'b0);
        check("R1 post-release road", is_road, 1'b0);
    endtask

    task automatic t_bounds();
        lane_en = '1; hmax = 12'd20;
        fill(100, 0); set_lane(0, 120); set_lane(LANES-1, 80);
        run_one("R2 inclusive bounds", 1'b1);
        fill(100, 0); set_lane(LANES-1, 121);
        run_one("R3 over +hmax last lane", 1'b0);
        fill(100, 0); set_lane(0, 79);
        run_one("R3 under -hmax first lane", 1'b0);
    endtask

    task automatic t_all_lanes();
        lane_en = '1; hmax = 12'd5;
        fill(-300, 3);
        run_one("R4 all pass", 1'b1);
        fill(-300, -5); set_lane(57, -306);
        run_one("R4 middle lane fails", 1'b0);
    endtask

    task automatic t_mask();
        hmax = 12'd5;
        fill(0, 0); set_lane(57, 900); set_lane(0, -900);
        lane_en = '1; lane_en[57] = 1'b0; lane_en[0] = 1'b0;
        run_one("R5 masked bad lanes", 1'b1);
        lane_en[57] = 1'b1;
        run_one("R5 unmasked bad lane", 1'b0);
        lane_en = '0;
        run_one("R6 empty mask", 1'b1);
        hmax = 12'hFFF;
        run_one("R6 empty mask negative tol", 1'b1);
    endtask

    task automatic t_extreme();
        lane_en = '1; hmax = 12'd2047;
        fill(-2048, 2047); set_lane(3, 2047);
        run_one("R7 span +4095", 1'b0);
        fill(2047, 0); set_lane(LANES-1, -2048);
        run_one("R7 span -4095", 1'b0);
        fill(0, 0); set_lane(5, 2047); set_lane(6, -2047);
        run_one("R7 full tol both signs", 1'b1);
    endtask

    task automatic t_neg_tol();
        lane_en = '1; hmax = 12'hFFF;
        fill(10, 0);
        run_one("R9 negative tol equal heights", 1'b0);
    endtask

    task automatic t_stream();
        lane_en = '1; hmax = 12'd4;
        fill(0, 0);
        in_valid = 1'b1;
        @(negedge clk);
        set_lane(9, 5);
        @(negedge clk);
        check("R8 stream A valid", out_valid, 1'b1);
        check("R8 stream A road", is_road, 1'b1);
        set_lane(9, 4);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 stream B valid", out_valid, 1'b1);
        check("R8 stream B road", is_road, 1'b0);
        @(negedge clk);
        check("R8 stream C valid", out_valid, 1'b1);
        check("R8 stream C road", is_road, 1'b1);
        @(negedge clk);
        check("R8 stream idle", out_valid, 1'b0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_bounds();
        t_all_lanes();
        t_mask();
        t_extreme();
        t_neg_tol();
        t_stream();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule